// File: doc/BRIEF.md
# Packed Lane SIMD Adder

This block adds or subtracts two 32-bit words as a set of independent narrow lanes. A lane-mode input splits each word into two 16-bit halfword lanes or four 8-bit byte lanes. Every lane forms its own sum or difference, and no carry or borrow crosses from one lane into the next. One operation therefore yields several packed results, which suits media data made of small elements.

Each lane either wraps modulo its width or saturates. Saturation clamps unsigned results to zero or the lane maximum, and signed results to the most negative or most positive lane value. A widen operation prepares bytes for halfword arithmetic: it zero-extends the two low bytes of the first operand into two 16-bit lanes. The operands, lane mode and operation are all sampled on the same clock edge. The packed result and one carry/overflow flag per lane appear, registered, one cycle later.

Top module: `lane_pack_alu`

## Requirements
- R1: With `lane_mode`=0 (halfword), `op_sel`=00 (add) forms result[31:16] from opa[31:16]+opb[31:16] and result[15:0] from opa[15:0]+opb[15:0], with no carry from bit 15 into bit 16.
- R2: With `lane_mode`=1 (byte), each byte lane i (bits 8i+7..8i) is computed from the matching bytes of opa and opb alone, with no carry between byte lanes.
- R3: `op_sel`=01 subtracts opb from opa lane by lane. With `sat_en`=0 both add and subtract wrap modulo 2^lane width.
- R4: With `sat_en`=1 and `sgn_en`=0, an unsigned add that overflows a lane yields all ones in that lane, and an unsigned subtract that borrows yields zero.
- R5: With `sat_en`=1 and `sgn_en`=1, a signed lane result above the lane maximum yields 0x7F (byte) or 0x7FFF (halfword), and one below the lane minimum yields 0x80 or 0x8000.
- R6: `lane_flag[i]` belongs to lane i, with lane 0 least significant. For `sgn_en`=0 it is the carry out (add) or the borrow (subtract). For `sgn_en`=1 it is two's-complement overflow. Its value does not depend on `sat_en`.
- R7: In halfword mode only `lane_flag[1:0]` carry meaning, and `lane_flag[3:2]` are 0.
- R8: `op_sel`=1x (widen) gives result[15:0]={8'h00,opa[7:0]}, result[31:16]={8'h00,opa[15:8]} and `lane_flag`=0. opb, `lane_mode`, `sat_en` and `sgn_en` have no effect on it.
- R9: A request with `in_valid`=1 produces `out_valid`=1 and its result on the next clock edge. Requests may arrive on every cycle, and `out_valid` is 0 in the cycle after `in_valid`=0.
- R10: While `rst_n`=0, `out_valid`, `result` and `lane_flag` are 0, whatever the inputs.
- R11: In a cycle with `in_valid`=0, `result` and `lane_flag` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opa | input | 32 | First packed operand |
| opb | input | 32 | Second packed operand (subtrahend for subtract) |
| lane_mode | input | 1 | 0 = two halfword lanes, 1 = four byte lanes |
| op_sel | input | 2 | 00 add, 01 subtract, 1x widen low bytes of opa |
| sat_en | input | 1 | 1 = saturate, 0 = wrap |
| sgn_en | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| out_valid | output | 1 | result and lane_flag hold a new value |
| result | output | 32 | Packed lane results |
| lane_flag | output | 4 | Per-lane carry/borrow or overflow |

## Verification
A carry chain that is gated wrongly at a lane boundary shows up in the first cycle after the operands are sampled. The neighbouring lane comes out off by one, and only for operand pairs whose low lane actually carries or borrows. For that reason the stimulus places carries and borrows right at bit 7, 15 and 23. A wrong overflow term appears at once, both as a flipped `lane_flag` and, in saturating mode, as a clamp value in place of a wrapped one. A capture enable that is stuck is visible on the first idle cycle, where the held result changes or `out_valid` fails to drop.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

    typedef enum logic {
        LM_HALF = 1'b0,
        LM_BYTE = 1'b1
    } lane_mode_e;

    typedef enum logic [1:0] {
        OP_ADD       = 2'b00,
        OP_SUB       = 2'b01,
        OP_WIDEN     = 2'b10,
        OP_WIDEN_ALT = 2'b11
    } op_e;

endpackage

// File: rtl/lpa_slice.sv
// One byte-wide adder slice; the carry-in is chosen by the top so that
// lane boundaries restart the chain.
module lpa_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    assign {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

endmodule

// File: rtl/lpa_clamp.sv
// Per-lane flag generation and saturation for a lane of width W.
module lpa_clamp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_eff,
    input  logic [W-1:0] sum,
    input  logic         cout,
    input  logic         is_sub,
    input  logic         sgn,
    input  logic         sat,
    output logic [W-1:0] res,
    output logic         flag
);

    logic ovf_signed;
    logic ovf_unsigned;

    always_comb begin
        // Signed overflow: both addends share a sign the sum lacks.
        ovf_signed   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        // Unsigned: carry out on add, missing carry (borrow) on subtract.
        ovf_unsigned = is_sub ? ~cout : cout;
        flag         = sgn ? ovf_signed : ovf_unsigned;

        res = sum;
        if (sat && flag) begin
            if (sgn) begin
                res = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
            end else begin
                res = is_sub ? {W{1'b0}} : {W{1'b1}};
            end
        end
    end

endmodule

// File: rtl/lpa_widen.sv
// Zero-extends each low byte of the operand into its own double-width lane.
module lpa_widen #(
    parameter int LANE_W     = 8,
    parameter int NUM_HALVES = 2
) (
    input  logic [NUM_HALVES*LANE_W-1:0]   a,
    output logic [NUM_HALVES*2*LANE_W-1:0] y
);

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_lane
        assign y[g*2*LANE_W +: 2*LANE_W] = {{LANE_W{1'b0}}, a[g*LANE_W +: LANE_W]};
    end

endmodule

// File: rtl/lane_pack_alu.sv
module lane_pack_alu
    import lpa_pkg::*;
#(
    parameter int LANE_W     = 8,
    parameter int NUM_SLICES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [LANE_W*NUM_SLICES-1:0]  opa,
    input  logic [LANE_W*NUM_SLICES-1:0]  opb,
    input  logic                          lane_mode,
    input  logic [1:0]                    op_sel,
    input  logic                          sat_en,
    input  logic                          sgn_en,
    output logic                          out_valid,
    output logic [LANE_W*NUM_SLICES-1:0]  result,
    output logic [NUM_SLICES-1:0]         lane_flag
);

    localparam int DATA_W     = LANE_W * NUM_SLICES;
    localparam int HALF_W     = 2 * LANE_W;
    localparam int NUM_HALVES = NUM_SLICES / 2;

    lane_mode_e mode_c;
    op_e        op_c;
    logic       is_sub;
    logic       is_widen;
    logic       byte_mode;

    assign mode_c    = lane_mode_e'(lane_mode);
    assign op_c      = op_e'(op_sel);
    assign is_sub    = (op_c == OP_SUB);
    assign is_widen  = (op_c == OP_WIDEN) || (op_c == OP_WIDEN_ALT);
    assign byte_mode = (mode_c == LM_BYTE);

    logic [DATA_W-1:0]      b_eff;
    logic [DATA_W-1:0]      sum_w;
    logic [NUM_SLICES-1:0]  cin_s;
    logic [NUM_SLICES-1:0]  cout_s;
    logic [DATA_W-1:0]      byte_res;
    logic [NUM_SLICES-1:0]  byte_flag;
    logic [DATA_W-1:0]      half_res;
    logic [NUM_HALVES-1:0]  half_flag;
    logic [DATA_W-1:0]      widen_res;

    assign b_eff = is_sub ? ~opb : opb;

    // Slice carry chain: even slices always start a lane; odd slices
    // continue the halfword lane or restart in byte mode.
    for (genvar gi = 0; gi < NUM_SLICES; gi++) begin : g_slice
        if (gi % 2 == 0) begin : g_head
            assign cin_s[gi] = is_sub;
        end else begin : g_tail
            assign cin_s[gi] = byte_mode ? is_sub : cout_s[gi-1];
        end

        lpa_slice #(.W(LANE_W)) u_slice (
            .a    (opa[gi*LANE_W +: LANE_W]),
            .b    (b_eff[gi*LANE_W +: LANE_W]),
            .cin  (cin_s[gi]),
            .sum  (sum_w[gi*LANE_W +: LANE_W]),
            .cout (cout_s[gi])
        );

        lpa_clamp #(.W(LANE_W)) u_byte_clamp (
            .a      (opa[gi*LANE_W +: LANE_W]),
            .b_eff  (b_eff[gi*LANE_W +: LANE_W]),
            .sum    (sum_w[gi*LANE_W +: LANE_W]),
            .cout   (cout_s[gi]),
            .is_sub (is_sub),
            .sgn    (sgn_en),
            .sat    (sat_en),
            .res    (byte_res[gi*LANE_W +: LANE_W]),
            .flag   (byte_flag[gi])
        );
    end

    for (genvar gh = 0; gh < NUM_HALVES; gh++) begin : g_half
        lpa_clamp #(.W(HALF_W)) u_half_clamp (
            .a      (opa[gh*HALF_W +: HALF_W]),
            .b_eff  (b_eff[gh*HALF_W +: HALF_W]),
            .sum    (sum_w[gh*HALF_W +: HALF_W]),
            .cout   (cout_s[2*gh+1]),
            .is_sub (is_sub),
            .sgn    (sgn_en),
            .sat    (sat_en),
            .res    (half_res[gh*HALF_W +: HALF_W]),
            .flag   (half_flag[gh])
        );
    end

    lpa_widen #(
        .LANE_W     (LANE_W),
        .NUM_HALVES (NUM_HALVES)
    ) u_widen (
        .a (opa[NUM_HALVES*LANE_W-1:0]),
        .y (widen_res)
    );

    logic [DATA_W-1:0]     next_res;
    logic [NUM_SLICES-1:0] next_flag;

    always_comb begin
        next_res  = half_res;
        next_flag = '0;
        if (is_widen) begin
            next_res = widen_res;
        end else begin
            unique case (mode_c)
                LM_BYTE: begin
                    next_res  = byte_res;
                    next_flag = byte_flag;
                end
                LM_HALF: begin
                    next_res                   = half_res;
                    next_flag[NUM_HALVES-1:0]  = half_flag;
                end
                default: begin
                    next_res  = half_res;
                    next_flag = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            lane_flag <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= next_res;
                lane_flag <= next_flag;
            end
        end
    end

endmodule

// File: rtl/lpa_checker.sv
module lpa_checker #(
    parameter int LANE_W     = 8,
    parameter int NUM_SLICES = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [LANE_W*NUM_SLICES-1:0]  opa,
    input logic [LANE_W*NUM_SLICES-1:0]  opb,
    input logic                          lane_mode,
    input logic [1:0]                    op_sel,
    input logic                          sat_en,
    input logic                          sgn_en,
    input logic                          out_valid,
    input logic [LANE_W*NUM_SLICES-1:0]  result,
    input logic [NUM_SLICES-1:0]         lane_flag
);

    localparam int DATA_W     = LANE_W * NUM_SLICES;
    localparam int HALF_W     = 2 * LANE_W;
    localparam int NUM_HALVES = NUM_SLICES / 2;

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(lane_flag)));

    p_half_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lane_mode && !op_sel[1])
        |=> (lane_flag[NUM_SLICES-1:NUM_HALVES] == '0));

    p_widen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[1])
        |=> ((lane_flag == '0) &&
             (result[HALF_W-1:0] == {{LANE_W{1'b0}}, $past(opa[LANE_W-1:0])})));

    p_top_byte_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode && op_sel == 2'b00 && !sat_en)
        |=> (result[DATA_W-1 -: LANE_W] ==
             $past(opa[DATA_W-1 -: LANE_W] + opb[DATA_W-1 -: LANE_W])));

    p_usat_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode && op_sel == 2'b00 && sat_en && !sgn_en)
        |=> (!lane_flag[0] || result[LANE_W-1:0] == {LANE_W{1'b1}}));

    p_usat_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode && op_sel == 2'b01 && sat_en && !sgn_en)
        |=> (!lane_flag[0] || result[LANE_W-1:0] == {LANE_W{1'b0}}));

    p_ssat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode && !op_sel[1] && sat_en && sgn_en)
        |=> (!lane_flag[0] ||
             result[LANE_W-1:0] == {1'b0, {(LANE_W-1){1'b1}}} ||
             result[LANE_W-1:0] == {1'b1, {(LANE_W-1){1'b0}}}));

endmodule

bind lane_pack_alu lpa_checker #(
    .LANE_W     (LANE_W),
    .NUM_SLICES (NUM_SLICES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opa       (opa),
    .opb       (opb),
    .lane_mode (lane_mode),
    .op_sel    (op_sel),
    .sat_en    (sat_en),
    .sgn_en    (sgn_en),
    .out_valid (out_valid),
    .result    (result),
    .lane_flag (lane_flag)
);

// File: tb/lane_pack_alu_tb.sv
module lane_pack_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        lane_mode = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic        sat_en = 1'b0;
    logic        sgn_en = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  lane_flag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [35:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_res = '0;
    logic [3:0]  last_flag = '0;
    bit          have_last = 1'b0;

    always #10 clk = ~clk;

    lane_pack_alu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opa       (opa),
        .opb       (opb),
        .lane_mode (lane_mode),
        .op_sel    (op_sel),
        .sat_en    (sat_en),
        .sgn_en    (sgn_en),
        .out_valid (out_valid),
        .result    (result),
        .lane_flag (lane_flag)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual flag=%h res=%h, expected flag=%h res=%h",
                     tag, act[35:32], act[31:0], exp[35:32], exp[31:0]);
        end
    endtask

    // One lane of width w from the requirements, in plain integer arithmetic.
    function automatic void lane_calc(input int w, input logic [15:0] ar, input logic [15:0] br,
                                      input logic sub, input logic sat, input logic sgn,
                                      output logic [15:0] r, output logic f);
        int mx, av, bv, full, smax, smin, val;
        mx   = (1 << w) - 1;
        smax = (1 << (w - 1)) - 1;
        smin = -(1 << (w - 1));
        av   = int'(ar) & mx;
        bv   = int'(br) & mx;
        if (sgn) begin
            if (ar[w-1]) av = av - (1 << w);
            if (br[w-1]) bv = bv - (1 << w);
        end
        full = sub ? av - bv : av + bv;
        if (sgn) f = (full > smax) || (full < smin);
        else     f = (full > mx) || (full < 0);
        val = full;
        if (sat && f) begin
            if (sgn) val = (full > smax) ? smax : smin;
            else     val = sub ? 0 : mx;
        end
        r = 16'(val & mx);
    endfunction

    function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic mode, input logic [1:0] op,
                                          input logic sat, input logic sgn);
        logic [31:0] res;
        logic [3:0]  fl;
        logic [15:0] r;
        logic        f;
        res = '0;
        fl  = '0;
        if (op[1]) begin
            res = {8'h00, a[15:8], 8'h00, a[7:0]};
        end else if (mode) begin
            for (int i = 0; i < 4; i++) begin
                lane_calc(8, {8'h00, a[i*8 +: 8]}, {8'h00, b[i*8 +: 8]}, op[0], sat, sgn, r, f);
                res[i*8 +: 8] = r[7:0];
                fl[i] = f;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                lane_calc(16, a[i*16 +: 16], b[i*16 +: 16], op[0], sat, sgn, r, f);
                res[i*16 +: 16] = r;
                fl[i] = f;
            end
        end
        return {fl, res};
    endfunction

    task automatic send(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic mode, input logic [1:0] op, input logic sat, input logic sgn);
        @(negedge clk);
        opa = a; opb = b; lane_mode = mode; op_sel = op; sat_en = sat; sgn_en = sgn;
        in_valid = 1'b1;
        exp_q.push_back(model(a, b, mode, op, sat, sgn));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opa = 32'hA5A5_5A5A ^ 32'(i);
            opb = 32'h1234_8765;
        end
    endtask

    // Monitor: pops the scoreboard on each valid output; on idle cycles
    // it checks that the previous result is held (R11).
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R9: actual out_valid=1, expected out_valid=0");
                end else begin
                    logic [35:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {lane_flag, result}, e);
                    last_res  = e[31:0];
                    last_flag = e[35:32];
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                check("R11 hold", {lane_flag, result}, {last_flag, last_res});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycles=%0d, expected below 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] sa;
        logic [31:0] sb;
        // R10: reset dominates even with a valid request pending.
        opa = 32'hFFFF_FFFF; opb = 32'h0101_0101; in_valid = 1'b1; lane_mode = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset result/flags", {lane_flag, result}, 36'h0);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R10: actual out_valid=%b, expected 0", out_valid);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // R1/R6: halfword add, carry out of low lane stays out of high lane.
        send("R1 half add carry at bit15", 32'h0001_FFFF, 32'h0001_0001, 1'b0, 2'b00, 1'b0, 1'b0);
        send("R1 half add high carry",     32'hFFFF_1234, 32'h0001_0000, 1'b0, 2'b00, 1'b0, 1'b0);
        // R2: byte add, wraps in each lane.
        send("R2 byte add independent",    32'hFF80_01FF, 32'h0180_0101, 1'b1, 2'b00, 1'b0, 1'b0);
        send("R2 byte add no carry",       32'h1122_3344, 32'h0102_0304, 1'b1, 2'b00, 1'b0, 1'b0);
        // R3: subtraction with wrap.
        send("R3 half sub borrow",         32'h0000_0005, 32'h0001_0007, 1'b0, 2'b01, 1'b0, 1'b0);
        send("R3 byte sub borrow",         32'h0010_0500, 32'h0101_0601, 1'b1, 2'b01, 1'b0, 1'b0);
        idle(2);
        // R4: unsigned saturation.
        send("R4 byte usat add",           32'hF010_FF80, 32'h2010_0180, 1'b1, 2'b00, 1'b1, 1'b0);
        send("R4 half usat sub",           32'h0005_0010, 32'h0006_0001, 1'b0, 2'b01, 1'b1, 1'b0);
        send("R4 byte usat sub",           32'h0102_0304, 32'h0203_0201, 1'b1, 2'b01, 1'b1, 1'b0);
        // R5: signed saturation.
        send("R5 byte ssat add",           32'h7F80_01FF, 32'h01FF_0101, 1'b1, 2'b00, 1'b1, 1'b1);
        send("R5 half ssat sub",           32'h8000_7FFF, 32'h0001_FFFF, 1'b0, 2'b01, 1'b1, 1'b1);
        send("R5 byte ssat sub",           32'h807F_0010, 32'h7F80_0120, 1'b1, 2'b01, 1'b1, 1'b1);
        // R6: signed overflow flags without saturation.
        send("R6 byte signed ovf wrap",    32'h7F80_4000, 32'h0180_4000, 1'b1, 2'b00, 1'b0, 1'b1);
        send("R6 half signed ovf wrap",    32'h7FFF_8000, 32'h0001_0001, 1'b0, 2'b01, 1'b0, 1'b1);
        // R7: halfword mode with byte-level carries: upper flags stay zero.
        send("R7 half flags upper zero",   32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'b00, 1'b0, 1'b0);
        idle(1);
        // R8: widen ignores opb, mode, saturation and sign.
        send("R8 widen half mode",         32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0, 2'b10, 1'b0, 1'b0);
        send("R8 widen byte sat sgn",      32'h0000_80FF, 32'h0123_4567, 1'b1, 2'b11, 1'b1, 1'b1);
        send("R8 widen other opb",         32'h0000_80FF, 32'hFEDC_BA98, 1'b0, 2'b10, 1'b1, 1'b0);
        idle(3);
        // R9: back-to-back mixed traffic.
        sa = 32'h1357_9BDF;
        sb = 32'h2468_ACE0;
        for (int k = 0; k < 48; k++) begin
            sa = sa * 32'd1103515245 + 32'd12345;
            sb = sb * 32'd22695477 + 32'd1;
            send("R9 back-to-back", sa, sb, sa[3], {sb[5] & sb[6], sb[4]}, sa[9], sb[11]);
        end
        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R9: actual %0d results missing, expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule